// File: doc/BRIEF.md
# SECDED Syndrome Generator and Locator

This block protects a 64-bit data word with 8 check bits. It uses a fixed parity-check matrix made of eight 64-bit masks. The same datapath serves two purposes. On the write side it produces the check byte for any data word. On the read side it takes a captured word together with its stored check byte, forms the syndrome, and classifies the result as one of four outcomes: clean, a single flipped data bit, a single flipped check bit, or an uncorrectable pattern. For the two single-bit outcomes it also returns the repaired word and check byte.

The faulty data bit is not found by reading the syndrome as a bit position. Instead, the syndrome is compared against all 64 columns of the matrix. Column i is the 8-bit vector formed by bit i of each check mask.

The output stage is selected by the parameter `PIPE`. With `PIPE=1` (the default) it is a small two-state machine with the states `STG_EMPTY` and `STG_FULL`. The transition `EMPTY->FULL` and the hold `FULL->FULL` are taken on any cycle where `in_valid` is high. The transition `FULL->EMPTY` and the hold `EMPTY->EMPTY` are taken on any cycle where `in_valid` is low. `out_valid` is high exactly in `STG_FULL`. With `PIPE=0` the outputs follow the inputs combinationally.

Top module: `secded_core`

## Requirements
- R1: `out_gen_check[k]` is the XOR of the data bits selected by mask k. Each mask is given as a high word (applied to data bits 63:32) and a low word (applied to bits 31:0):
  - k0 = f00fe11e/c33c0ff7
  - k1 = 00ff00ff/00fff0ff
  - k2 = 0f0f0f0f/0f0fff00
  - k3 = 11113333/7777000f
  - k4 = 22224444/8888222f
  - k5 = 44448888/ffff4441
  - k6 = 8888ffff/11118882
  - k7 = ffff1111/22221114
- R2: `out_syndrome` equals the check byte generated from `in_data`, XORed with `in_check`.
- R3: A zero syndrome gives `out_class` = 0 (clean) and `out_index` = 0. The data and check byte pass through unchanged.
- R4: If the syndrome equals column i, that is the vector {mask7[i], ..., mask0[i]}, then `out_class` = 1 and `out_index` = i. The lowest matching i wins. `out_data_fix` is `in_data` with bit i inverted, and `out_check_fix` equals `in_check`.
- R5: If no column matches and exactly one syndrome bit k is set, then `out_class` = 2 and `out_index` = k. `out_check_fix` is `in_check` with bit k inverted, and the data is unchanged.
- R6: If no column matches and two or more syndrome bits are set, then `out_class` = 3 and `out_index` = 0. No correction is applied. Any two-bit flip falls in this class.
- R7: With `PIPE=1`, every result appears one cycle after the cycle in which `in_valid` was high. `out_valid` is high in exactly those cycles, including back-to-back inputs.
- R8: While `rst_n` is low, `out_valid` and every registered output are 0.
- R9: With `PIPE=1`, a cycle with `in_valid` low leaves every result output unchanged, whatever values appear on `in_data` and `in_check`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input word is valid this cycle |
| in_data | input | 64 | Data word (to encode, or as captured) |
| in_check | input | 8 | Stored check byte of the captured word |
| out_valid | output | 1 | Result outputs are valid |
| out_gen_check | output | 8 | Check byte generated from in_data |
| out_syndrome | output | 8 | Generated XOR stored check byte |
| out_class | output | 2 | 0 clean, 1 data bit, 2 check bit, 3 uncorrectable |
| out_index | output | 6 | Faulty bit index for class 1 or 2, else 0 |
| out_data_fix | output | 64 | Corrected data word |
| out_check_fix | output | 8 | Corrected check byte |

## Verification
The bound checker watches every cycle for the following properties:
- The handshake timing and hold behaviour of the output stage.
- The link between syndrome, generated byte and stored byte.
- The correction shape of each class: a single-bit data repair leaves the check byte alone, a check repair leaves the data alone, and the clean and uncorrectable classes alter nothing.

Only the bench scenarios can show that the located index is the right one. The bench covers all 64 data flips and all 8 check flips, shows that double flips land in the uncorrectable class, and checks that the repaired word equals the original.

// File: rtl/secded_pkg.sv
package secded_pkg;

    localparam int DW = 64;
    localparam int CW = 8;
    localparam int IW = $clog2(DW);

    // Parity-check masks, entry k drives check bit k.
    localparam logic [DW-1:0] PCM [CW] = '{
        64'hf00fe11e_c33c0ff7,
        64'h00ff00ff_00fff0ff,
        64'h0f0f0f0f_0f0fff00,
        64'h11113333_7777000f,
        64'h22224444_8888222f,
        64'h44448888_ffff4441,
        64'h8888ffff_11118882,
        64'hffff1111_22221114
    };

    typedef enum logic [1:0] {
        SYN_CLEAN = 2'd0,
        SYN_DATA  = 2'd1,
        SYN_CHECK = 2'd2,
        SYN_FATAL = 2'd3
    } syn_class_e;

    typedef enum logic {
        STG_EMPTY = 1'b0,
        STG_FULL  = 1'b1
    } stg_state_e;

endpackage

// File: rtl/secded_parity.sv
module secded_parity
    import secded_pkg::*;
(
    input  logic [DW-1:0] data,
    output logic [CW-1:0] chk
);

    for (genvar k = 0; k < CW; k++) begin : g_bit
        assign chk[k] = ^(data & PCM[k]);
    end

endmodule

// File: rtl/secded_locator.sv
module secded_locator
    import secded_pkg::*;
(
    input  logic [CW-1:0] syn,
    output syn_class_e    cls,
    output logic [IW-1:0] idx
);

    logic [CW-1:0] col [DW];
    logic [DW-1:0] hit;

    // Column i of the matrix: bit i of every mask.
    for (genvar i = 0; i < DW; i++) begin : g_col
        for (genvar k = 0; k < CW; k++) begin : g_row
            assign col[i][k] = PCM[k][i];
        end
        assign hit[i] = (syn == col[i]);
    end

    logic [IW-1:0] didx;
    logic [IW-1:0] cidx;

    always_comb begin
        didx = '0;
        for (int i = DW - 1; i >= 0; i--) begin
            if (hit[i]) didx = IW'(i);
        end
    end

    always_comb begin
        cidx = '0;
        for (int k = CW - 1; k >= 0; k--) begin
            if (syn[k]) cidx = IW'(k);
        end
    end

    always_comb begin
        if (syn == '0) begin
            cls = SYN_CLEAN;
            idx = '0;
        end else if (|hit) begin
            cls = SYN_DATA;
            idx = didx;
        end else if ($countones(syn) == 1) begin
            cls = SYN_CHECK;
            idx = cidx;
        end else begin
            cls = SYN_FATAL;
            idx = '0;
        end
    end

endmodule

// File: rtl/secded_fix.sv
module secded_fix
    import secded_pkg::*;
(
    input  logic [DW-1:0] data,
    input  logic [CW-1:0] chk,
    input  syn_class_e    cls,
    input  logic [IW-1:0] idx,
    output logic [DW-1:0] data_fix,
    output logic [CW-1:0] chk_fix
);

    logic [DW-1:0] dflip;
    logic [CW-1:0] cflip;

    always_comb begin
        dflip = '0;
        cflip = '0;
        unique case (cls)
            SYN_DATA:  dflip = DW'(1) << idx;
            SYN_CHECK: cflip = CW'(1) << idx[$clog2(CW)-1:0];
            SYN_CLEAN,
            SYN_FATAL: ;
        endcase
    end

    assign data_fix = data ^ dflip;
    assign chk_fix  = chk ^ cflip;

endmodule

// File: rtl/secded_core.sv
module secded_core
    import secded_pkg::*;
#(
    parameter int PIPE = 1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        in_valid,
    input  logic [63:0] in_data,
    input  logic [7:0]  in_check,
    output logic        out_valid,
    output logic [7:0]  out_gen_check,
    output logic [7:0]  out_syndrome,
    output logic [1:0]  out_class,
    output logic [5:0]  out_index,
    output logic [63:0] out_data_fix,
    output logic [7:0]  out_check_fix
);

    logic [CW-1:0] gen_c;
    logic [CW-1:0] syn_c;
    syn_class_e    cls_c;
    logic [IW-1:0] idx_c;
    logic [DW-1:0] dfix_c;
    logic [CW-1:0] cfix_c;

    secded_parity u_parity (
        .data (in_data),
        .chk  (gen_c)
    );

    assign syn_c = gen_c ^ in_check;

    secded_locator u_locator (
        .syn (syn_c),
        .cls (cls_c),
        .idx (idx_c)
    );

    secded_fix u_fix (
        .data     (in_data),
        .chk      (in_check),
        .cls      (cls_c),
        .idx      (idx_c),
        .data_fix (dfix_c),
        .chk_fix  (cfix_c)
    );

    if (PIPE != 0) begin : g_pipe
        stg_state_e    state_q;
        stg_state_e    state_d;
        logic [CW-1:0] gen_q;
        logic [CW-1:0] syn_q;
        syn_class_e    cls_q;
        logic [IW-1:0] idx_q;
        logic [DW-1:0] dfix_q;
        logic [CW-1:0] cfix_q;

        always_ff @(posedge clk) begin
            if (!rst_n) state_q <= STG_EMPTY;
            else        state_q <= state_d;
        end

        always_comb begin
            unique case (state_q)
                STG_EMPTY: state_d = in_valid ? STG_FULL : STG_EMPTY;
                STG_FULL:  state_d = in_valid ? STG_FULL : STG_EMPTY;
            endcase
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                gen_q  <= '0;
                syn_q  <= '0;
                cls_q  <= SYN_CLEAN;
                idx_q  <= '0;
                dfix_q <= '0;
                cfix_q <= '0;
            end else if (in_valid) begin
                gen_q  <= gen_c;
                syn_q  <= syn_c;
                cls_q  <= cls_c;
                idx_q  <= idx_c;
                dfix_q <= dfix_c;
                cfix_q <= cfix_c;
            end
        end

        assign out_valid     = (state_q == STG_FULL);
        assign out_gen_check = gen_q;
        assign out_syndrome  = syn_q;
        assign out_class     = cls_q;
        assign out_index     = idx_q;
        assign out_data_fix  = dfix_q;
        assign out_check_fix = cfix_q;
    end else begin : g_comb
        assign out_valid     = in_valid;
        assign out_gen_check = gen_c;
        assign out_syndrome  = syn_c;
        assign out_class     = cls_c;
        assign out_index     = idx_c;
        assign out_data_fix  = dfix_c;
        assign out_check_fix = cfix_c;
    end

endmodule

// File: rtl/secded_core_chk.sv
module secded_core_chk #(
    parameter int PIPE = 1
) (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic [63:0] in_data,
    input logic [7:0]  in_check,
    input logic        out_valid,
    input logic [7:0]  out_gen_check,
    input logic [7:0]  out_syndrome,
    input logic [1:0]  out_class,
    input logic [5:0]  out_index,
    input logic [63:0] out_data_fix,
    input logic [7:0]  out_check_fix
);

    localparam bit PIPED = (PIPE != 0);

    // R7
    valid_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (PIPED && in_valid) |=> out_valid);

    // R7
    valid_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (PIPED && !in_valid) |=> !out_valid);

    // R9
    hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (PIPED && !in_valid) |=> ($stable(out_data_fix) && $stable(out_class)
                                  && $stable(out_syndrome)));

    // R2
    syndrome_rel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (PIPED && out_valid) |-> (out_syndrome == (out_gen_check ^ $past(in_check))));

    // R3
    clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (PIPED && out_valid && out_class == 2'd0) |->
        (out_syndrome == 8'd0 && out_data_fix == $past(in_data)
         && out_check_fix == $past(in_check)));

    // R4
    data_fix_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (PIPED && out_valid && out_class == 2'd1) |->
        ($countones(out_data_fix ^ $past(in_data)) == 1
         && out_check_fix == $past(in_check)));

    // R5
    check_fix_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (PIPED && out_valid && out_class == 2'd2) |->
        ($onehot0(out_syndrome) && out_index < 6'd8
         && out_data_fix == $past(in_data)
         && $countones(out_check_fix ^ $past(in_check)) == 1));

    // R6
    fatal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (PIPED && out_valid && out_class == 2'd3) |->
        ($countones(out_syndrome) > 1 && out_index == 6'd0
         && out_data_fix == $past(in_data) && out_check_fix == $past(in_check)));

endmodule

bind secded_core secded_core_chk #(.PIPE(PIPE)) u_secded_core_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .in_valid      (in_valid),
    .in_data       (in_data),
    .in_check      (in_check),
    .out_valid     (out_valid),
    .out_gen_check (out_gen_check),
    .out_syndrome  (out_syndrome),
    .out_class     (out_class),
    .out_index     (out_index),
    .out_data_fix  (out_data_fix),
    .out_check_fix (out_check_fix)
);

// File: tb/test_secded_core.sv
module test_secded_core;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [63:0] in_data = '0;
    logic [7:0]  in_check = '0;
    logic        out_valid;
    logic [7:0]  out_gen_check;
    logic [7:0]  out_syndrome;
    logic [1:0]  out_class;
    logic [5:0]  out_index;
    logic [63:0] out_data_fix;
    logic [7:0]  out_check_fix;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    secded_core #(.PIPE(1)) i_secded_core (
        .clk           (clk),
        .rst_n         (rst_n),
        .in_valid      (in_valid),
        .in_data       (in_data),
        .in_check      (in_check),
        .out_valid     (out_valid),
        .out_gen_check (out_gen_check),
        .out_syndrome  (out_syndrome),
        .out_class     (out_class),
        .out_index     (out_index),
        .out_data_fix  (out_data_fix),
        .out_check_fix (out_check_fix)
    );

    // Masks from R1, check bit k uses entry k.
    localparam logic [63:0] MASK [8] = '{
        64'hf00fe11e_c33c0ff7, 64'h00ff00ff_00fff0ff,
        64'h0f0f0f0f_0f0fff00, 64'h11113333_7777000f,
        64'h22224444_8888222f, 64'h44448888_ffff4441,
        64'h8888ffff_11118882, 64'hffff1111_22221114
    };

    typedef struct packed {
        logic [63:0] data;
        logic [63:0] dflip;
        logic [7:0]  cflip;
        logic [1:0]  cls;
        logic [5:0]  idx;
    } vec_t;

    localparam int NVEC = 10;
    localparam vec_t VEC [NVEC] = '{
        '{64'h0000_0000_0000_0000, 64'h0,                   8'h00, 2'd0, 6'd0},
        '{64'hdead_beef_0bad_f00d, 64'h0,                   8'h00, 2'd0, 6'd0},
        '{64'hffff_ffff_ffff_ffff, 64'h1,                   8'h00, 2'd1, 6'd0},
        '{64'h1234_5678_9abc_def0, 64'h8000_0000_0000_0000, 8'h00, 2'd1, 6'd63},
        '{64'h1234_5678_9abc_def0, 64'h0000_0001_0000_0000, 8'h00, 2'd1, 6'd32},
        '{64'haaaa_aaaa_aaaa_aaaa, 64'h0,                   8'h01, 2'd2, 6'd0},
        '{64'h5555_5555_5555_5555, 64'h0,                   8'h80, 2'd2, 6'd7},
        '{64'hcafe_f00d_1357_9bdf, 64'h3,                   8'h00, 2'd3, 6'd0},
        '{64'hcafe_f00d_1357_9bdf, 64'h10,                  8'h04, 2'd3, 6'd0},
        '{64'h0000_0000_0000_0000, 64'h0,                   8'h11, 2'd3, 6'd0}
    };

    function automatic logic [7:0] ref_chk(input logic [63:0] d);
        logic [7:0] c;
        for (int k = 0; k < 8; k++) c[k] = ^(d & MASK[k]);
        return c;
    endfunction

    function automatic string cls_tag(input logic [1:0] c);
        case (c)
            2'd0:    return "R3";
            2'd1:    return "R4";
            2'd2:    return "R5";
            default: return "R6";
        endcase
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic apply(input logic [63:0] d, input logic [7:0] c);
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = d;
        in_check = c;
        @(negedge clk);
        in_valid = 1'b0;
        in_data  = ~d;
        in_check = ~c;
    endtask

    task automatic run_vec(input logic [63:0] d, input logic [63:0] dflip,
                           input logic [7:0] cflip, input logic [1:0] ecls,
                           input logic [5:0] eidx);
        logic [63:0] sd;
        logic [7:0]  sc;
        string       t;
        sd = d ^ dflip;
        sc = ref_chk(d) ^ cflip;
        t  = cls_tag(ecls);
        apply(sd, sc);
        chk("R7 out_valid", out_valid, 1'b1);
        chk("R1 gen_check", out_gen_check, ref_chk(sd));
        chk("R2 syndrome", out_syndrome, ref_chk(sd) ^ sc);
        chk({t, " class"}, out_class, ecls);
        chk({t, " index"}, out_index, eidx);
        chk({t, " data_fix"}, out_data_fix, (ecls == 2'd3) ? sd : d);
        chk({t, " check_fix"}, out_check_fix, (ecls == 2'd3) ? sc : ref_chk(d));
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL R7 watchdog expired actual=hung expected=done");
            summary();
            $finish;
        end
    end

    initial begin
        logic [63:0] base;
        logic [63:0] held;

        // R8: reset state
        repeat (3) @(negedge clk);
        in_valid = 1'b1;
        in_data  = 64'h1111_2222_3333_4444;
        @(negedge clk);
        chk("R8 out_valid", out_valid, 1'b0);
        chk("R8 data_fix", out_data_fix, 64'h0);
        chk("R8 syndrome", out_syndrome, 8'h0);
        chk("R8 class", out_class, 2'd0);
        in_valid = 1'b0;
        rst_n    = 1'b1;

        // Vector table
        for (int v = 0; v < NVEC; v++)
            run_vec(VEC[v].data, VEC[v].dflip, VEC[v].cflip, VEC[v].cls, VEC[v].idx);

        // Every single data-bit and check-bit flip
        base = 64'h0123_4567_89ab_cdef;
        for (int i = 0; i < 64; i++) run_vec(base, 64'h1 << i, 8'h0, 2'd1, 6'(i));
        for (int k = 0; k < 8; k++) run_vec(base, 64'h0, 8'h1 << k, 2'd2, 6'(k));

        // Double flips
        for (int i = 0; i < 63; i += 3)
            run_vec(~base, (64'h1 << i) | (64'h1 << (i + 1)), 8'h0, 2'd3, 6'd0);
        for (int k = 0; k < 7; k++)
            run_vec(base, 64'h0, (8'h1 << k) | (8'h1 << (k + 1)), 2'd3, 6'd0);
        for (int k = 0; k < 8; k++)
            run_vec(base, 64'h1 << (k * 7), 8'h1 << k, 2'd3, 6'd0);

        // R7 and R9: timing and hold
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = base;
        in_check = ref_chk(base) ^ 8'h20;
        #1 chk("R7 not yet valid", out_valid, 1'b0);
        @(negedge clk);
        in_valid = 1'b0;
        in_data  = 64'hffff_0000_ffff_0000;
        in_check = 8'h5a;
        chk("R7 valid after one cycle", out_valid, 1'b1);
        chk("R5 timed class", out_class, 2'd2);
        held = out_data_fix;
        @(negedge clk);
        chk("R7 valid drops", out_valid, 1'b0);
        chk("R9 data held", out_data_fix, held);
        chk("R9 class held", out_class, 2'd2);
        chk("R9 index held", out_index, 6'd5);

        // R7: back-to-back inputs
        in_valid = 1'b1;
        in_data  = base ^ 64'h4;
        in_check = ref_chk(base);
        @(negedge clk);
        chk("R7 first result valid", out_valid, 1'b1);
        chk("R4 first index", out_index, 6'd2);
        in_data  = base;
        in_check = ref_chk(base);
        @(negedge clk);
        in_valid = 1'b0;
        chk("R7 second result valid", out_valid, 1'b1);
        chk("R3 second class", out_class, 2'd0);
        chk("R3 second data", out_data_fix, base);

        // R8: reset clears a loaded stage
        rst_n = 1'b0;
        @(negedge clk);
        chk("R8 valid after reset", out_valid, 1'b0);
        chk("R8 check_fix after reset", out_check_fix, 8'h0);
        rst_n = 1'b1;

        done = 1'b1;
        summary();
        $finish;
    end

endmodule